// File: doc/BRIEF.md
# Custom-Instruction Interrupt Controller Unit

This unit sits beside the execute stage of a small 32-bit integer core and handles interrupts without privileged trap registers. It latches 32 request lines into a pending set, keeps a run-time mask and a build-time permanent mask, and holds four 32-bit banked scratch registers. When an unmasked request is pending and no handler is running, the unit preempts the instruction presented to it. It redirects the program counter to a fixed handler address, saves the address of the preempted instruction, and hands the handler a bitmask of every request accepted at that moment.

The core passes each decoded instruction to the unit with its operand value and program counter. The unit recognises five custom-opcode operations. Two copy values between a general register and a banked register. One returns from the handler, one swaps the mask, and one waits for a request. Results come back in the same cycle, and state changes take effect from the next cycle. Two internal fault strobes feed request bits 1 and 2. A fault whose own bit is masked stops the processor.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the run-time mask is all ones, eoi is zero, halted is low and no handler is active.
- R2: An instruction is recognised only with opcode 0001011, funct3 000, rs2 00000 and funct7 0 to 4. Any other combination gives no result and changes no state.
- R3: funct7 0000001 (setq) writes the operand value into banked register q[rd_qsel]. funct7 0000000 (getq) returns q[rs1_qsel] as a result in the same cycle.
- R4: funct7 0000011 (maskirq) returns the current mask as the result and loads the operand value into the mask from the next cycle.
- R5: When an instruction is presented, no handler is active, the unit is not halted and (pending AND NOT mask) is nonzero, the instruction is not executed and the unit redirects to HANDLER_PC in that cycle. From the next cycle q0 holds that instruction's pc, q1 and eoi hold the accepted set, and the accepted pending bits are cleared.
- R6: While a handler is active, no further entry occurs and new requests stay latched as pending.
- R7: funct7 0000010 (retirq) redirects to q0 in the same cycle, clears eoi and ends the handler from the next cycle, so a request still pending enters at the next instruction.
- R8: funct7 0000100 (waitirq) asserts stall while no pending bit is set, whatever the mask. Otherwise it returns the pending bitmask as the result.
- R9: Request bits set in PERM_MASK never become pending and never enter.
- R10: A request line is sampled at each clock edge, and its pending bit stays set after the line drops until an entry accepts it.
- R11: fault_break sets request bit 1 and fault_misalign sets request bit 2.
- R12: A fault whose bit is masked (run-time or permanent mask) sets halted from the next cycle. halted stays set until reset, and while it is set no instruction gives a result or a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Instruction funct3 field |
| funct7 | input | 7 | Instruction funct7 field |
| rs2_field | input | 5 | Instruction rs2 field |
| rd_qsel | input | 2 | Low bits of the rd field (setq target) |
| rs1_qsel | input | 2 | Low bits of the rs1 field (getq source) |
| src_val | input | 32 | Value of the rs1 operand |
| pc_cur | input | 32 | Address of the presented instruction |
| irq_lines | input | 32 | External request lines |
| fault_break | input | 1 | Breakpoint or illegal-instruction strobe |
| fault_misalign | input | 1 | Misaligned-access strobe |
| res_valid | output | 1 | res_data is to be written to rd |
| res_data | output | 32 | Result value |
| redirect_valid | output | 1 | Program counter redirect this cycle |
| redirect_pc | output | 32 | Redirect target |
| stall | output | 1 | Hold the presented instruction |
| eoi | output | 32 | Requests being served by the active handler |
| halted | output | 1 | Processor stop after a masked fault |

## Verification
Result, redirect and stall are combinational on the presented instruction, so the bench drives inputs on the falling edge and samples them 1 ns later, in the same cycle. Mask, banked registers, eoi and halted change at the next rising edge, and the bench reads them at the following falling edge, through eoi or through a later getq or maskirq. A request pulsed across one rising edge is pending from that edge, so the bench presents the instruction that should be preempted in the next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N = 32;
  localparam logic [6:0] CUSTOM_OPC = 7'b0001011;
  localparam int BRK_BIT = 1;
  localparam int MIS_BIT = 2;

  typedef enum logic [2:0] {
    OP_NONE, OP_GETQ, OP_SETQ, OP_RETIRQ, OP_MASKIRQ, OP_WAITIRQ
  } irq_op_e;

  function automatic irq_op_e decode_op(input logic [6:0] opc, input logic [2:0] f3,
                                        input logic [6:0] f7, input logic [4:0] rs2);
    irq_op_e op;
    op = OP_NONE;
    if (opc == CUSTOM_OPC && f3 == 3'd0 && rs2 == 5'd0) begin
      case (f7)
        7'd0: op = OP_GETQ;
        7'd1: op = OP_SETQ;
        7'd2: op = OP_RETIRQ;
        7'd3: op = OP_MASKIRQ;
        7'd4: op = OP_WAITIRQ;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

  function automatic logic [IRQ_N-1:0] merge_sources(input logic [IRQ_N-1:0] lines,
                                                     input logic brk, input logic mis);
    logic [IRQ_N-1:0] s;
    s = lines;
    s[BRK_BIT] = s[BRK_BIT] | brk;
    s[MIS_BIT] = s[MIS_BIT] | mis;
    return s;
  endfunction
endpackage

// File: rtl/irq_qbank.sv
module irq_qbank #(
  parameter int XLEN  = 32,
  parameter int QREGS = 4,
  localparam int QSEL_W = $clog2(QREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [QSEL_W-1:0] wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              entry_en,
  input  logic [XLEN-1:0]   entry_ret,
  input  logic [XLEN-1:0]   entry_set,
  input  logic [QSEL_W-1:0] rd_sel,
  output logic [XLEN-1:0]   rd_data,
  output logic [XLEN-1:0]   q0_out
);
  logic [XLEN-1:0] qr [QREGS];

  for (genvar g = 0; g < QREGS; g++) begin : g_q
    if (g == 0) begin : g_ret
      always_ff @(posedge clk) begin
        if (!rst_n) qr[g] <= '0;
        else if (entry_en) qr[g] <= entry_ret;
        else if (wr_en && wr_sel == QSEL_W'(g)) qr[g] <= wr_data;
      end
    end else if (g == 1) begin : g_set
      always_ff @(posedge clk) begin
        if (!rst_n) qr[g] <= '0;
        else if (entry_en) qr[g] <= entry_set;
        else if (wr_en && wr_sel == QSEL_W'(g)) qr[g] <= wr_data;
      end
    end else begin : g_scratch
      always_ff @(posedge clk) begin
        if (wr_en && wr_sel == QSEL_W'(g)) qr[g] <= wr_data;
      end
    end
  end

  assign rd_data = qr[rd_sel];
  assign q0_out  = qr[0];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 32,
  parameter logic [N-1:0] PERM = '0,
  parameter int BRK_BIT = 1,
  parameter int MIS_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         present,
  input  logic [N-1:0] src,
  input  logic         brk,
  input  logic         mis,
  input  logic         retire,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] active,
  output logic [N-1:0] eoi_q,
  output logic         in_hdl,
  output logic         halted,
  output logic         take
);
  logic [N-1:0] mask_eff;
  logic         fault_stop;

  assign mask_eff   = mask_q | PERM;
  assign active     = pend_q & ~mask_eff;
  assign take       = present && !in_hdl && !halted && (|active);
  assign fault_stop = (brk && mask_eff[BRK_BIT]) || (mis && mask_eff[MIS_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
      eoi_q  <= '0;
      in_hdl <= 1'b0;
      halted <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(take ? active : '0)) | (src & ~PERM);
      if (mask_we) mask_q <= mask_wd;
      if (take) begin
        eoi_q  <= active;
        in_hdl <= 1'b1;
      end else if (retire) begin
        eoi_q  <= '0;
        in_hdl <= 1'b0;
      end
      if (fault_stop) halted <= 1'b1;
    end
  end

  p_eoi_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (eoi_q != '0) && in_hdl);
  p_eoi_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (eoi_q == '0) && !in_hdl);
  p_mask_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wd));
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_perm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & PERM) == '0);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit #(
  parameter int XLEN = 32,
  parameter logic [31:0] PERM_MASK = 32'h0000_0000,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic [6:0]  funct7,
  input  logic [4:0]  rs2_field,
  input  logic [1:0]  rd_qsel,
  input  logic [1:0]  rs1_qsel,
  input  logic [31:0] src_val,
  input  logic [31:0] pc_cur,
  input  logic [31:0] irq_lines,
  input  logic        fault_break,
  input  logic        fault_misalign,
  output logic        res_valid,
  output logic [31:0] res_data,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic        stall,
  output logic [31:0] eoi,
  output logic        halted
);
  import irq_pkg::*;

  localparam int QREGS = 4;

  irq_op_e     op;
  logic        take, exec, in_hdl;
  logic [31:0] mask_q, pend_q, active, sources;
  logic [31:0] q_rd, q0;

  assign op      = decode_op(opcode, funct3, funct7, rs2_field);
  assign sources = merge_sources(irq_lines, fault_break, fault_misalign);
  assign exec    = instr_valid && !halted && !take && op != OP_NONE;

  irq_pending #(.N(IRQ_N), .PERM(PERM_MASK), .BRK_BIT(BRK_BIT), .MIS_BIT(MIS_BIT)) u_pend (
    .clk(clk), .rst_n(rst_n), .present(instr_valid), .src(sources),
    .brk(fault_break), .mis(fault_misalign),
    .retire(exec && op == OP_RETIRQ),
    .mask_we(exec && op == OP_MASKIRQ), .mask_wd(src_val),
    .mask_q(mask_q), .pend_q(pend_q), .active(active), .eoi_q(eoi),
    .in_hdl(in_hdl), .halted(halted), .take(take)
  );

  irq_qbank #(.XLEN(XLEN), .QREGS(QREGS)) u_qbank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(exec && op == OP_SETQ), .wr_sel(rd_qsel), .wr_data(src_val),
    .entry_en(take), .entry_ret(pc_cur), .entry_set(active),
    .rd_sel(rs1_qsel), .rd_data(q_rd), .q0_out(q0)
  );

  always_comb begin
    res_valid = 1'b0;
    res_data  = '0;
    stall     = 1'b0;
    if (exec) begin
      case (op)
        OP_GETQ:    begin res_valid = 1'b1; res_data = q_rd; end
        OP_MASKIRQ: begin res_valid = 1'b1; res_data = mask_q; end
        OP_WAITIRQ: begin
          if (pend_q == '0) stall = 1'b1;
          else begin res_valid = 1'b1; res_data = pend_q; end
        end
        default: ;
      endcase
    end
  end

  assign redirect_valid = take || (exec && op == OP_RETIRQ);
  assign redirect_pc    = take ? HANDLER_PC : q0;

  p_ret_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> q0 == $past(pc_cur));
  p_wait_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op == OP_WAITIRQ) |-> res_data != '0);
  p_no_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hdl && !(exec && op == OP_RETIRQ)) |=> $stable(q0));
  p_halt_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !res_valid && !redirect_valid);
endmodule

// File: tb/irq_ctrl_unit_test.sv
module irq_ctrl_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] PERM = 32'h8000_0000;
  localparam logic [31:0] HPC  = 32'h0000_0010;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0;
  logic [6:0] opcode = 0, funct7 = 0;
  logic [2:0] funct3 = 0;
  logic [4:0] rs2_field = 0;
  logic [1:0] rd_qsel = 0, rs1_qsel = 0;
  logic [31:0] src_val = 0, pc_cur = 0, irq_lines = 0;
  logic fault_break = 0, fault_misalign = 0;
  logic res_valid, redirect_valid, stall, halted;
  logic [31:0] res_data, redirect_pc, eoi;
  logic o_rv, o_redir, o_stall;
  logic [31:0] o_res, o_rpc;
  int n_chk = 0, n_fail = 0;

  irq_ctrl_unit #(.PERM_MASK(PERM), .HANDLER_PC(HPC)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .funct3(funct3), .funct7(funct7), .rs2_field(rs2_field), .rd_qsel(rd_qsel),
    .rs1_qsel(rs1_qsel), .src_val(src_val), .pc_cur(pc_cur), .irq_lines(irq_lines),
    .fault_break(fault_break), .fault_misalign(fault_misalign), .res_valid(res_valid),
    .res_data(res_data), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stall(stall), .eoi(eoi), .halted(halted));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue_raw(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                           input logic [1:0] rdq, input logic [1:0] rsq,
                           input logic [31:0] val, input logic [31:0] pc);
    instr_valid = 1; opcode = opc; funct3 = f3; funct7 = f7; rs2_field = 0;
    rd_qsel = rdq; rs1_qsel = rsq; src_val = val; pc_cur = pc;
    #1;
    o_rv = res_valid; o_res = res_data; o_redir = redirect_valid;
    o_rpc = redirect_pc; o_stall = stall;
    @(posedge clk); @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic issue(input logic [6:0] f7, input logic [1:0] rdq, input logic [1:0] rsq,
                       input logic [31:0] val, input logic [31:0] pc);
    issue_raw(7'b0001011, 3'd0, f7, rdq, rsq, val, pc);
  endtask

  task automatic pulse(input logic [31:0] lines, input logic brk, input logic mis);
    irq_lines = lines; fault_break = brk; fault_misalign = mis;
    @(posedge clk); @(negedge clk);
    irq_lines = 0; fault_break = 0; fault_misalign = 0;
  endtask

  task automatic t_reset;
    chk(eoi == 0, "R1 eoi", eoi, 0);
    chk(halted == 0, "R1 halted", {31'b0, halted}, 0);
    issue(7'd3, 0, 0, 32'h0, 32'h100);
    chk(o_rv && o_res == 32'hFFFF_FFFF, "R1 mask all ones", o_res, 32'hFFFF_FFFF);
    chk(!o_redir, "R1 no entry", {31'b0, o_redir}, 0);
  endtask

  task automatic t_qregs;
    issue(7'd1, 2, 0, 32'h0000_A5A5, 32'h104);
    issue(7'd1, 3, 0, 32'h0000_1234, 32'h108);
    issue(7'd0, 0, 2, 32'h0, 32'h10C);
    chk(o_rv && o_res == 32'h0000_A5A5, "R3 getq q2", o_res, 32'h0000_A5A5);
    issue(7'd0, 0, 3, 32'h0, 32'h110);
    chk(o_rv && o_res == 32'h0000_1234, "R3 getq q3", o_res, 32'h0000_1234);
  endtask

  task automatic t_decode;
    issue_raw(7'b0001011, 3'd1, 7'd1, 2, 0, 32'hDEAD, 32'h114);
    chk(!o_rv, "R2 funct3 nonzero", {31'b0, o_rv}, 0);
    issue(7'd0, 0, 2, 32'h0, 32'h118);
    chk(o_res == 32'h0000_A5A5, "R2 q2 untouched", o_res, 32'h0000_A5A5);
    issue(7'd7, 0, 0, 32'h0, 32'h11C);
    chk(!o_rv && !o_redir, "R2 funct7 unknown", {31'b0, o_rv}, 0);
    issue_raw(7'b0110011, 3'd0, 7'd3, 0, 0, 32'h55, 32'h120);
    chk(!o_rv, "R2 wrong opcode", {31'b0, o_rv}, 0);
  endtask

  task automatic t_mask;
    issue(7'd3, 0, 0, 32'h0000_00F0, 32'h124);
    chk(o_res == 32'h0, "R4 R2 old mask", o_res, 0);
    issue(7'd3, 0, 0, 32'h0, 32'h128);
    chk(o_res == 32'h0000_00F0, "R4 new mask", o_res, 32'h0000_00F0);
  endtask

  task automatic t_entry_ret;
    pulse(32'h0000_0028, 0, 0);
    issue(7'd0, 0, 2, 32'h0, 32'h200);
    chk(o_redir && o_rpc == HPC && !o_rv, "R5 R10 entry", o_rpc, HPC);
    chk(eoi == 32'h28, "R5 eoi", eoi, 32'h28);
    issue(7'd0, 0, 0, 32'h0, 32'h204);
    chk(o_res == 32'h200, "R5 q0", o_res, 32'h200);
    issue(7'd0, 0, 1, 32'h0, 32'h208);
    chk(o_res == 32'h28, "R5 q1", o_res, 32'h28);
    issue(7'd4, 0, 0, 32'h0, 32'h20C);
    chk(o_stall && !o_rv, "R8 stall when empty", {31'b0, o_stall}, 1);
    pulse(32'h0000_0080, 0, 0);
    issue(7'd0, 0, 0, 32'h0, 32'h210);
    chk(!o_redir && o_res == 32'h200, "R6 no nesting", o_res, 32'h200);
    issue(7'd4, 0, 0, 32'h0, 32'h214);
    chk(!o_stall && o_rv && o_res == 32'h80, "R8 R6 pending kept", o_res, 32'h80);
    issue(7'd2, 0, 0, 32'h0, 32'h218);
    chk(o_redir && o_rpc == 32'h200, "R7 return pc", o_rpc, 32'h200);
    chk(eoi == 0, "R7 eoi cleared", eoi, 0);
    issue(7'd0, 0, 0, 32'h0, 32'h300);
    chk(o_redir && o_rpc == HPC, "R7 reentry", o_rpc, HPC);
    chk(eoi == 32'h80, "R7 eoi second", eoi, 32'h80);
    issue(7'd2, 0, 0, 32'h0, 32'h304);
    chk(o_rpc == 32'h300, "R7 return second", o_rpc, 32'h300);
  endtask

  task automatic t_perm;
    pulse(32'h8000_0000, 0, 0);
    issue(7'd0, 0, 2, 32'h0, 32'h308);
    chk(!o_redir && o_res == 32'h0000_A5A5, "R9 no entry", {31'b0, o_redir}, 0);
    issue(7'd4, 0, 0, 32'h0, 32'h30C);
    chk(o_stall, "R9 never pending", {31'b0, o_stall}, 1);
  endtask

  task automatic t_maskblock;
    issue(7'd3, 0, 0, 32'h10, 32'h310);
    pulse(32'h10, 0, 0);
    issue(7'd0, 0, 2, 32'h0, 32'h314);
    chk(!o_redir, "R4 masked no entry", {31'b0, o_redir}, 0);
    issue(7'd4, 0, 0, 32'h0, 32'h318);
    chk(!o_stall && o_res == 32'h10, "R8 masked still pending", o_res, 32'h10);
    issue(7'd3, 0, 0, 32'h0, 32'h31C);
    chk(o_rv && !o_redir && o_res == 32'h10, "R4 unmask swap", o_res, 32'h10);
    issue(7'd0, 0, 2, 32'h0, 32'h400);
    chk(o_redir && o_rpc == HPC, "R10 held until accepted", o_rpc, HPC);
    issue(7'd0, 0, 1, 32'h0, 32'h404);
    chk(o_res == 32'h10, "R5 q1 masked case", o_res, 32'h10);
    issue(7'd2, 0, 0, 32'h0, 32'h408);
    chk(o_rpc == 32'h400, "R7 return", o_rpc, 32'h400);
  endtask

  task automatic t_internal;
    pulse(0, 1, 0);
    issue(7'd0, 0, 2, 32'h0, 32'h500);
    chk(o_redir, "R11 break entry", {31'b0, o_redir}, 1);
    issue(7'd0, 0, 1, 32'h0, 32'h504);
    chk(o_res == 32'h2, "R11 break bit", o_res, 32'h2);
    issue(7'd2, 0, 0, 32'h0, 32'h508);
    pulse(0, 0, 1);
    issue(7'd0, 0, 2, 32'h0, 32'h600);
    chk(o_redir, "R11 misalign entry", {31'b0, o_redir}, 1);
    issue(7'd0, 0, 1, 32'h0, 32'h604);
    chk(o_res == 32'h4, "R11 misalign bit", o_res, 32'h4);
    issue(7'd2, 0, 0, 32'h0, 32'h608);
    chk(halted == 0, "R12 unmasked fault no halt", {31'b0, halted}, 0);
  endtask

  task automatic t_halt;
    issue(7'd3, 0, 0, 32'h2, 32'h700);
    pulse(0, 1, 0);
    chk(halted == 1, "R12 halted", {31'b0, halted}, 1);
    issue(7'd0, 0, 2, 32'h0, 32'h704);
    chk(!o_rv && !o_redir, "R12 silent", {31'b0, o_rv}, 0);
    chk(halted == 1, "R12 sticky", {31'b0, halted}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_qregs();
    t_decode();
    t_mask();
    t_entry_ret();
    t_perm();
    t_maskblock();
    t_internal();
    t_halt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule